// File: doc/BRIEF.md
# Rate-Accumulator PWM Bank with Direction Outputs

This block generates pulse-width-modulated drive signals for several motor channels. A 16-bit fractional rate accumulator, advanced by a programmable increment on every system clock, produces a count tick on each carry out. Every channel has a counter that advances on that tick, and a comparator that sets its PWM level. Each channel drives two pins. These carry either PWM plus a direction level, or two separate PWM signals, one per direction.

Software writes a small word-addressed register bank through a single-cycle write strobe. Each channel has a signed (sign-magnitude) duty word and a mode word. The mode word selects the resolution, sawtooth or triangle counting, the pin style and whether duty updates wait for a period boundary. A shared word holds one enable bit per channel, and one word holds the rate increment.

Top module: `pwm_dds_bank`

## Requirements
- R1: After reset every duty, mode, enable and rate register is zero and the accumulator is cleared, so both pins of every channel stay low.
- R2: A write address is {region[2:0], channel[CH_AW-1:0]}. Region 0 is the duty word, 1 the mode word, 2 the rate increment and 4 the enable word. The channel field applies to regions 0 and 1. Writes to regions 3, 5, 6 and 7 change nothing, and a write to one channel leaves the others untouched.
- R3: A tick is issued one cycle after the 16-bit sum of the accumulator and the rate increment carries out, giving a tick rate of f_clk*rate/65536. Doubling the rate halves the PWM period.
- R4: In sawtooth mode (mode bit 2 = 0) a period lasts 2^n ticks. The PWM level is high while the count is below D, so it is high for D ticks per period. D is the top n bits of the magnitude field, duty word bits [30:16].
- R5: Mode bits [1:0] give the resolution n = 9 + code, so codes 0 to 3 select 9 to 12 bits.
- R6: In triangle mode (mode bit 2 = 1) the count runs up and then back down, so a period lasts 2^(n+1) ticks and the level is high for 2*D ticks.
- R7: With mode bit 4 clear, pin A carries the PWM level and pin B carries the sign bit (duty word bit 31).
- R8: With mode bit 4 set, pin A carries PWM and pin B is low when the sign is clear. When the sign is set, pin B carries PWM and pin A is low. The two pins are never high together.
- R9: Bit i of the enable word gates channel i. While it is clear, both pins of that channel are low. This holds from the cycle after the enable word is written.
- R10: With mode bit 5 set, a new duty word (magnitude and sign) takes effect only at the start of the next period. With the bit clear, it takes effect in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3+CH_AW | Write address {region, channel} |
| wrData | input | 32 | Write data |
| pinA | output | NCH | Per-channel output A (PWM or up-PWM) |
| pinB | output | NCH | Per-channel output B (direction or down-PWM) |

## Verification
A register write is taken at the clock edge where the strobe is sampled. The pins reflect the new duty, mode or enable from that edge on, unless the channel waits for a period boundary. The rate increment works through the accumulator register and then the tick register, so a new rate moves the counters from the second edge after the write. The checks therefore do not look at single edges. After each change the bench skips the first rising edge of the pin under test, then measures one whole period between the next two rising edges, counting total cycles and high cycles. Rate settings of 32768 and 16384 give exactly one tick every two or four clocks, so the expected counts are exact integers. The deferred-update check samples at fixed cycle offsets from an observed period start.

// File: rtl/pwm_dds_pkg.sv
`timescale 1ns/1ps
package pwm_dds_pkg;

  localparam int ACC_W   = 16;          // rate accumulator width
  localparam int MIN_RES = 9;           // resolution for width code 0
  localparam int MAX_RES = MIN_RES + 3; // resolution for width code 3
  localparam int CNT_W   = MAX_RES + 1; // phase counter covers triangle mode
  localparam int LIM_W   = CNT_W + 1;
  localparam int MAG_W   = 15;          // magnitude field of the duty word
  localparam int MODE_W  = 6;

  typedef enum logic [2:0] {
    REG_DUTY   = 3'd0,
    REG_MODE   = 3'd1,
    REG_RATE   = 3'd2,
    REG_SPARE  = 3'd3,
    REG_ENABLE = 3'd4
  } regSel_e;

  // Packed from MSB: bit5 dblBuf, bits4:3 style, bit2 symmetric, bits1:0 width
  typedef struct packed {
    logic       dblBuf;
    logic [1:0] style;
    logic       symmetric;
    logic [1:0] widthCode;
  } modeCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_dds_ctrl.sv
`timescale 1ns/1ps
module pwm_dds_ctrl
  import pwm_dds_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CH_AW  = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  output logic [NCH-1:0][DATA_W-1:0]    dutyRegs,
  output modeCfg_t [NCH-1:0]            modeRegs,
  output logic [NCH-1:0]                enableReg,
  output pwmStrobe_t                    strobe
);

  logic [2:0]       region;
  logic [CH_AW-1:0] chan;
  logic             chanOk;
  logic             hitDuty, hitMode, hitRate, hitEnable;

  assign region = wrAddr[ADDR_W-1 -: 3];
  assign chan   = wrAddr[CH_AW-1:0];
  assign chanOk = (32'(chan) < NCH);

  always_comb begin
    hitDuty   = wrEn && chanOk && (region == REG_DUTY);
    hitMode   = wrEn && chanOk && (region == REG_MODE);
    hitRate   = wrEn && (region == REG_RATE);
    hitEnable = wrEn && (region == REG_ENABLE);
  end

  // Shared registers
  logic [ACC_W-1:0] rateReg;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   accSum;
  logic             tickQ;

  assign accSum = {1'b0, acc} + {1'b0, rateReg};

  always_ff @(posedge clk) begin
    if (rst) begin
      rateReg   <= '0;
      enableReg <= '0;
      acc       <= '0;
      tickQ     <= 1'b0;
    end else begin
      if (hitRate)   rateReg   <= wrData[ACC_W-1:0];
      if (hitEnable) enableReg <= wrData[NCH-1:0];
      acc   <= accSum[ACC_W-1:0];
      tickQ <= accSum[ACC_W];
    end
  end

  assign strobe.tick = tickQ;

  // Per-channel registers
  for (genvar c = 0; c < NCH; c++) begin : g_reg
    logic           sel;
    logic [DATA_W-1:0] dutyQ;
    modeCfg_t       modeQ;

    assign sel = (chan == CH_AW'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        dutyQ <= '0;
        modeQ <= '0;
      end else begin
        if (hitDuty && sel) dutyQ <= wrData;
        if (hitMode && sel) modeQ <= modeCfg_t'(wrData[MODE_W-1:0]);
      end
    end

    assign dutyRegs[c] = dutyQ;
    assign modeRegs[c] = modeQ;
  end

endmodule

// File: rtl/pwm_dds_datapath.sv
`timescale 1ns/1ps
module pwm_dds_datapath
  import pwm_dds_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NCH-1:0][DATA_W-1:0] dutyRegs,
  input  modeCfg_t [NCH-1:0]         modeRegs,
  input  logic [NCH-1:0]             enableReg,
  input  pwmStrobe_t                 strobe,
  output logic [NCH-1:0]             pinA,
  output logic [NCH-1:0]             pinB
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    modeCfg_t          cfg;
    logic [CNT_W-1:0]  phase;
    logic [DATA_W-1:0] shadow, effDuty;
    logic [3:0]        res;
    logic [LIM_W-1:0]  limit;
    logic [CNT_W-1:0]  lowMask, low, folded;
    logic [MAG_W-1:0]  mag, duty;
    logic              wrapNow, upperHalf, pwmRaw, sign;
    logic              aOut, bOut;

    assign cfg = modeRegs[c];

    always_comb begin
      res       = 4'(MIN_RES) + {2'b00, cfg.widthCode};
      limit     = (LIM_W'(1) << (res + {3'b000, cfg.symmetric})) - LIM_W'(1);
      lowMask   = (CNT_W'(1) << res) - CNT_W'(1);
      low       = phase & lowMask;
      upperHalf = cfg.symmetric && phase[res];
      folded    = upperHalf ? (lowMask - low) : low;
      wrapNow   = strobe.tick && ({1'b0, phase} >= limit);
      effDuty   = cfg.dblBuf ? shadow : dutyRegs[c];
      mag       = effDuty[DATA_W-2 -: MAG_W];
      duty      = mag >> (4'(MAG_W) - res);
      sign      = effDuty[DATA_W-1];
      pwmRaw    = (MAG_W'(folded) < duty);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        phase  <= '0;
        shadow <= '0;
      end else begin
        if (strobe.tick) phase <= wrapNow ? '0 : phase + CNT_W'(1);
        if (!cfg.dblBuf || wrapNow) shadow <= dutyRegs[c];
      end
    end

    always_comb begin
      aOut = 1'b0;
      bOut = 1'b0;
      if (enableReg[c]) begin
        if (cfg.style[1]) begin
          aOut = pwmRaw && !sign;
          bOut = pwmRaw && sign;
        end else begin
          aOut = pwmRaw;
          bOut = sign;
        end
      end
    end

    assign pinA[c] = aOut;
    assign pinB[c] = bOut;
  end

endmodule

// File: rtl/pwm_dds_bank.sv
`timescale 1ns/1ps
module pwm_dds_bank
  import pwm_dds_pkg::*;
#(
  parameter int  NCH    = 4,
  localparam int CH_AW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = 3 + CH_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output logic [NCH-1:0]    pinA,
  output logic [NCH-1:0]    pinB
);

  logic [NCH-1:0][31:0] dutyRegs;
  modeCfg_t [NCH-1:0]   modeRegs;
  logic [NCH-1:0]       enableReg;
  pwmStrobe_t           strobe;

  pwm_dds_ctrl #(
    .NCH(NCH), .CH_AW(CH_AW), .ADDR_W(ADDR_W), .DATA_W(32)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dutyRegs(dutyRegs), .modeRegs(modeRegs), .enableReg(enableReg),
    .strobe(strobe)
  );

  pwm_dds_datapath #(
    .NCH(NCH), .DATA_W(32)
  ) u_dp (
    .clk(clk), .rst(rst), .dutyRegs(dutyRegs), .modeRegs(modeRegs),
    .enableReg(enableReg), .strobe(strobe), .pinA(pinA), .pinB(pinB)
  );

endmodule

// File: rtl/pwm_dds_chk.sv
`timescale 1ns/1ps
module pwm_dds_chk
  import pwm_dds_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    wrAddr,
  input logic [31:0]          wrData,
  input logic [NCH-1:0][31:0] dutyRegs,
  input modeCfg_t [NCH-1:0]   modeRegs,
  input logic [NCH-1:0]       enableReg,
  input logic [NCH-1:0]       pinA,
  input logic [NCH-1:0]       pinB
);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R9
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
      !enableReg[c] |-> (!pinA[c] && !pinB[c]));

    // R9
    enable_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wrEn && (wrAddr[ADDR_W-1 -: 3] == 3'd4) && !wrData[c]) |=> (!pinA[c] && !pinB[c]));

    // R8
    updown_excl_chk: assert property (@(posedge clk) disable iff (rst)
      modeRegs[c].style[1] |-> !(pinA[c] && pinB[c]));

    // R7
    dir_pin_chk: assert property (@(posedge clk) disable iff (rst)
      (enableReg[c] && !modeRegs[c].style[1] && !modeRegs[c].dblBuf)
        |-> (pinB[c] == dutyRegs[c][31]));
  end

endmodule

bind pwm_dds_bank pwm_dds_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .dutyRegs(dutyRegs), .modeRegs(modeRegs), .enableReg(enableReg),
  .pinA(pinA), .pinB(pinB)
);

// File: tb/tb_pwm_dds_bank.sv
`timescale 1ns/1ps
module tb_pwm_dds_bank;

  localparam int NCH    = 4;
  localparam int CH_AW  = 2;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0]       wrData = '0;
  logic [NCH-1:0]    pinA, pinB;
  logic [2*NCH-1:0]  pinsAll;

  assign pinsAll = {pinB, pinA};

  always #2.5 clk = ~clk;

  pwm_dds_bank #(.NCH(NCH)) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinA(pinA), .pinB(pinB)
  );

  typedef struct {
    bit    isPulse;
    int    pinIdx;
    int    expHigh;
    int    expPeriod;
    int    expLevel;
    int    cycles;
    string tag;
  } item_t;

  item_t q[$];
  int nChecks = 0;
  int nFail   = 0;
  int nDone   = 0;
  int nPushed = 0;

  // Index helpers: 0..3 pin A of a channel, 4..7 pin B
  function automatic int pA(input int ch); return ch; endfunction
  function automatic int pB(input int ch); return NCH + ch; endfunction

  function automatic logic [31:0] dutyWord(input int d, input int n, input bit neg);
    logic [31:0] w;
    w = 32'(d) << (16 + 15 - n);
    if (neg) w[31] = 1'b1;
    return w;
  endfunction

  task automatic regWrite(input int region, input int ch, input logic [31:0] data);
    @(negedge clk);
    wrEn   = 1'b1;
    wrAddr = ADDR_W'((region << CH_AW) | ch);
    wrData = data;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic expectPulse(input int idx, input int high, input int period, input string tag);
    item_t it;
    it.isPulse = 1'b1; it.pinIdx = idx; it.expHigh = high; it.expPeriod = period;
    it.expLevel = 0; it.cycles = 0; it.tag = tag;
    q.push_back(it);
    nPushed++;
    wait (nDone == nPushed);
  endtask

  task automatic expectStatic(input int idx, input int level, input int cycles, input string tag);
    item_t it;
    it.isPulse = 1'b0; it.pinIdx = idx; it.expHigh = 0; it.expPeriod = 0;
    it.expLevel = level; it.cycles = cycles; it.tag = tag;
    q.push_back(it);
    nPushed++;
    wait (nDone == nPushed);
  endtask

  task automatic waitRise(input int idx);
    logic prev;
    logic cur;
    @(negedge clk);
    prev = pinsAll[idx];
    forever begin
      @(negedge clk);
      cur = pinsAll[idx];
      if (!prev && cur) break;
      prev = cur;
    end
  endtask

  task automatic directCheck(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and measures the pins
  initial begin
    forever begin
      item_t it;
      wait (q.size() > 0);
      it = q.pop_front();
      if (it.isPulse) begin
        int h;
        int p;
        logic prev;
        logic cur;
        waitRise(it.pinIdx);
        waitRise(it.pinIdx);
        h = 1; p = 1; prev = 1'b1;
        forever begin
          @(negedge clk);
          cur = pinsAll[it.pinIdx];
          if (!prev && cur) break;
          prev = cur;
          p++;
          if (cur) h++;
        end
        nChecks++;
        if (h != it.expHigh || p != it.expPeriod) begin
          nFail++;
          $display("FAIL %s: high %0d period %0d, expected high %0d period %0d",
                   it.tag, h, p, it.expHigh, it.expPeriod);
        end
      end else begin
        int bad = 0;
        int seen = 0;
        for (int k = 0; k < it.cycles; k++) begin
          @(negedge clk);
          if (int'(pinsAll[it.pinIdx]) != it.expLevel) begin
            bad++;
            seen = int'(pinsAll[it.pinIdx]);
          end
        end
        nChecks++;
        if (bad != 0) begin
          nFail++;
          $display("FAIL %s: pin %0d read %0d on %0d cycles, expected %0d",
                   it.tag, it.pinIdx, seen, bad, it.expLevel);
        end
      end
      nDone++;
    end
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  // Driver
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: everything idle after reset
    expectStatic(pA(0), 0, 40, "R1 pinA0 after reset");
    expectStatic(pB(0), 0, 40, "R1 pinB0 after reset");

    // R4 / R3 baseline: 9-bit sawtooth, one tick per two clocks
    regWrite(2, 0, 32'd32768);
    regWrite(0, 0, dutyWord(100, 9, 0));
    regWrite(4, 0, 32'h1);
    expectPulse(pA(0), 200, 1024, "R4 sawtooth duty 100");
    expectStatic(pB(0), 0, 100, "R7 direction low for positive");

    // R3: half the rate doubles the period
    regWrite(2, 0, 32'd16384);
    expectPulse(pA(0), 400, 2048, "R3 rate 16384");
    regWrite(2, 0, 32'd32768);

    // R2: unassigned regions ignored
    regWrite(3, 0, 32'hFFFF_FFFF);
    regWrite(5, 0, 32'hFFFF_FFFF);
    regWrite(6, 0, 32'hFFFF_FFFF);
    regWrite(7, 0, 32'hFFFF_FFFF);
    expectPulse(pA(0), 200, 1024, "R2 spare regions ignored");

    // R2: channel select
    regWrite(0, 1, dutyWord(50, 9, 0));
    regWrite(4, 0, 32'h3);
    expectPulse(pA(1), 100, 1024, "R2 channel 1 duty 50");
    expectPulse(pA(0), 200, 1024, "R2 channel 0 untouched");

    // R5: resolution codes
    regWrite(0, 0, 32'h2000_0000);
    regWrite(1, 0, 32'h1);
    expectPulse(pA(0), 512, 2048, "R5 width code 1");
    regWrite(1, 0, 32'h3);
    expectPulse(pA(0), 2048, 8192, "R5 width code 3");
    regWrite(1, 0, 32'h0);
    expectPulse(pA(0), 256, 1024, "R5 width code 0 truncation");

    // R6: triangle counting
    regWrite(0, 0, dutyWord(100, 9, 0));
    regWrite(1, 0, 32'h4);
    expectPulse(pA(0), 400, 2048, "R6 triangle duty 100");

    // R7: direction follows the sign
    regWrite(1, 0, 32'h0);
    regWrite(0, 0, dutyWord(100, 9, 1));
    expectPulse(pA(0), 200, 1024, "R7 pwm on A when negative");
    expectStatic(pB(0), 1, 100, "R7 direction high for negative");

    // R8: split up/down pins
    regWrite(1, 0, 32'h10);
    expectPulse(pB(0), 200, 1024, "R8 down pin pulses");
    expectStatic(pA(0), 0, 1100, "R8 up pin idle for negative");
    regWrite(0, 0, dutyWord(100, 9, 0));
    expectPulse(pA(0), 200, 1024, "R8 up pin pulses");
    expectStatic(pB(0), 0, 1100, "R8 down pin idle for positive");

    // R9: enable gating
    regWrite(1, 0, 32'h0);
    regWrite(0, 0, dutyWord(100, 9, 1));
    regWrite(4, 0, 32'h2);
    expectStatic(pA(0), 0, 1100, "R9 pinA0 disabled");
    expectStatic(pB(0), 0, 100, "R9 pinB0 disabled");
    expectPulse(pA(1), 100, 1024, "R9 channel 1 still enabled");

    // R10: deferred duty update
    regWrite(4, 0, 32'h1);
    regWrite(2, 0, 32'd16384);
    regWrite(0, 0, dutyWord(50, 9, 0));
    regWrite(1, 0, 32'h20);
    expectPulse(pA(0), 200, 2048, "R10 buffered duty 50");
    waitRise(pA(0));
    repeat (100) @(negedge clk);
    regWrite(0, 0, dutyWord(10, 9, 0));
    repeat (18) @(negedge clk);
    directCheck(pinA[0] == 1'b1, "R10 buffered write deferred", int'(pinA[0]), 1);
    expectPulse(pA(0), 40, 2048, "R10 buffered duty 10 next period");

    regWrite(1, 0, 32'h0);
    regWrite(0, 0, dutyWord(50, 9, 0));
    expectPulse(pA(0), 200, 2048, "R10 unbuffered duty 50");
    waitRise(pA(0));
    repeat (100) @(negedge clk);
    regWrite(0, 0, dutyWord(10, 9, 0));
    directCheck(pinA[0] == 1'b0, "R10 unbuffered write immediate", int'(pinA[0]), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule